// File: doc/BRIEF.md
# Current-source inverter carrier-PWM gate generator

This block turns a carrier-based PWM decision, of the kind normally used for a voltage-source bridge, into the six switch gates of a three-phase current-source bridge. Each of the three signed modulating samples is compared with a shared triangular carrier to give one leg bit per phase. The leg bits are mapped onto one upper and one lower switch command. When the mapping leaves no upper switch conducting, or no lower switch conducting, a shorting pulse is added. This pulse keeps a path open for the DC link current. It is always placed on the two switches of a single leg.

The leg that takes the shorting pulse comes from the fundamental phase angle. The 0 to 359 degree range is split into three 120-degree windows, so over one fundamental period each leg carries the freewheeling current for an equal share of the time. The six gates are registered, so they all change on the same clock edge. The carrier and the modulating samples are generated upstream. Dead time and commutation overlap are handled downstream.

Top module: `csi_gate_gen`

## Requirements
- R1: The leg bit of a phase is 1 only when its modulating sample is strictly greater than the carrier, with both read as signed two's-complement values. An equal or smaller sample gives 0.
- R2: The legs are a, b and c, and the leg after c is a. Switch numbering is S1..S6 on gate_o bits 0..5. The upper switches S1, S3 and S5 belong to legs a, b and c. The lower switches S4, S6 and S2 belong to legs a, b and c.
- R3: When the leg bits are not all equal, no shorting pulse is added. The upper switch of a leg is on exactly when that leg's bit is 1 and the next leg's bit is 0. The lower switch of a leg is on exactly when that leg's bit is 0 and the next leg's bit is 1.
- R4: When all three leg bits are equal (all 0 or all 1), a shorting pulse is added. Only the upper and lower switch of the selected leg are on, and the other four gates are off.
- R5: The shorting pulse goes to a leg chosen by phase_i. Values 0 to 119 select leg a (S1, S4). Values 120 to 239 select leg b (S3, S6). Values 240 and above select leg c (S5, S2).
- R6: From the first clock edge after reset onward, exactly one upper gate and exactly one lower gate are high.
- R7: gate_o shows the inputs that were sampled at the previous rising clock edge. All six gates update together on that edge and hold their values between edges.
- R8: While rst_n is low, gate_o is all zero. It stays zero until the first rising edge after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| carrier_i | input | DATA_W | Signed triangular carrier sample |
| mod_a_i | input | DATA_W | Signed modulating sample, leg a |
| mod_b_i | input | DATA_W | Signed modulating sample, leg b |
| mod_c_i | input | DATA_W | Signed modulating sample, leg c |
| phase_i | input | PH_W | Fundamental phase angle in degrees, 0 to 359 |
| gate_o | output | 6 | Switch gates, bit n-1 drives switch Sn |

## Verification
The assertions assume that rst_n is released in step with clk and that the inputs are settled at each rising edge. Under those conditions the mapping and the shorting logic give exactly one upper and one lower gate for any input values, including phase values outside 0 to 359. The stimulus changes inputs only at falling edges or just after a rising edge. It uses a bench-side triangle carrier with random modulating samples, and it deliberately forces samples equal to the carrier. It also steps the phase across every window boundary and past 359, so that the tie rule and the leg selection are both exercised.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int NLEG = 3;
  localparam int NSW  = 2 * NLEG;

  typedef logic [NLEG-1:0] leg_vec_t;

  // Gate index of the upper switch of leg k (S1, S3, S5).
  function automatic int upper_idx(input int k);
    return 2 * k;
  endfunction

  // Gate index of the lower switch of leg k (S4, S6, S2).
  function automatic int lower_idx(input int k);
    return (2 * k + NLEG) % NSW;
  endfunction
endpackage

// File: rtl/csi_leg_cmp.sv
module csi_leg_cmp
  import csi_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] carrier_i,
  input  logic signed [DATA_W-1:0] mod_i [NLEG],
  output leg_vec_t                 leg_o
);

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    always_comb begin
      leg_o[k] = (mod_i[k] > carrier_i);
    end

    // R1: a tie with the carrier never raises the leg bit
    p_tie_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_i[k] == carrier_i) |-> !leg_o[k]);
  end

endmodule

// File: rtl/csi_leg_map.sv
module csi_leg_map
  import csi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  leg_vec_t leg_i,
  output leg_vec_t upper_o,
  output leg_vec_t lower_o
);

  for (genvar k = 0; k < NLEG; k++) begin : g_map
    localparam int NXT = (k + 1) % NLEG;
    always_comb begin
      upper_o[k] =  leg_i[k] & ~leg_i[NXT];
      lower_o[k] = ~leg_i[k] &  leg_i[NXT];
    end
  end

  // R4: equal leg bits leave the bridge with no conducting pair
  p_equal_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_i == '0) || (leg_i == '1)) |-> ((upper_o == '0) && (lower_o == '0)));

  // R3: mixed leg bits give one upper and one lower command
  p_mixed_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_i != '0) && (leg_i != '1)) |->
      (($countones(upper_o) == 1) && ($countones(lower_o) == 1)));

endmodule

// File: rtl/csi_short_steer.sv
module csi_short_steer
  import csi_pkg::*;
#(
  parameter int PH_W       = 9,
  parameter int PHASE_SPAN = 360
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_i,
  input  leg_vec_t        upper_i,
  input  leg_vec_t        lower_i,
  output leg_vec_t        upper_o,
  output leg_vec_t        lower_o
);

  localparam int              WIN_I  = PHASE_SPAN / NLEG;
  localparam logic [PH_W-1:0] EDGE_B = PH_W'(WIN_I);
  localparam logic [PH_W-1:0] EDGE_C = PH_W'(2 * WIN_I);

  leg_vec_t sel;
  logic     short_req;

  always_comb begin
    sel    = '0;
    sel[0] = (phase_i < EDGE_B);
    sel[1] = (phase_i >= EDGE_B) && (phase_i < EDGE_C);
    sel[2] = (phase_i >= EDGE_C);
  end

  always_comb begin
    short_req = (upper_i == '0) || (lower_i == '0);
    upper_o   = upper_i | ({NLEG{short_req}} & sel);
    lower_o   = lower_i | ({NLEG{short_req}} & sel);
  end

  // R5: exactly one leg window is active for any phase value
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  // R4: a shorting pulse lands on one leg pair only
  p_short_leg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    short_req |-> ((upper_o == lower_o) && ($countones(upper_o) == 1)));

endmodule

// File: rtl/csi_gate_gen.sv
module csi_gate_gen
  import csi_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int PH_W       = 9,
  parameter int PHASE_SPAN = 360
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] carrier_i,
  input  logic signed [DATA_W-1:0] mod_a_i,
  input  logic signed [DATA_W-1:0] mod_b_i,
  input  logic signed [DATA_W-1:0] mod_c_i,
  input  logic        [PH_W-1:0]   phase_i,
  output logic        [NSW-1:0]    gate_o
);

  logic signed [DATA_W-1:0] mod_arr [NLEG];
  leg_vec_t                 leg_bits;
  leg_vec_t                 upper_raw, lower_raw;
  leg_vec_t                 upper_fin, lower_fin;
  logic        [NSW-1:0]    gate_d;
  logic        [NSW-1:0]    gate_q;
  logic                     out_vld_q;
  leg_vec_t                 upper_q, lower_q;

  always_comb begin
    mod_arr[0] = mod_a_i;
    mod_arr[1] = mod_b_i;
    mod_arr[2] = mod_c_i;
  end

  csi_leg_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_i (carrier_i),
    .mod_i     (mod_arr),
    .leg_o     (leg_bits)
  );

  csi_leg_map u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .leg_i   (leg_bits),
    .upper_o (upper_raw),
    .lower_o (lower_raw)
  );

  csi_short_steer #(.PH_W(PH_W), .PHASE_SPAN(PHASE_SPAN)) u_steer (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_i),
    .upper_i (upper_raw),
    .lower_i (lower_raw),
    .upper_o (upper_fin),
    .lower_o (lower_fin)
  );

  for (genvar k = 0; k < NLEG; k++) begin : g_pack
    always_comb begin
      gate_d[upper_idx(k)] = upper_fin[k];
      gate_d[lower_idx(k)] = lower_fin[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q    <= '0;
      out_vld_q <= 1'b0;
    end else begin
      gate_q    <= gate_d;
      out_vld_q <= 1'b1;
    end
  end

  assign gate_o = gate_q;

  for (genvar k = 0; k < NLEG; k++) begin : g_unpack
    always_comb begin
      upper_q[k] = gate_q[upper_idx(k)];
      lower_q[k] = gate_q[lower_idx(k)];
    end
  end

  // R6: the registered bridge always has one upper and one lower gate on
  p_one_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_q |-> ($countones(upper_q) == 1));

  p_one_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_q |-> ($countones(lower_q) == 1));

endmodule

// File: tb/csi_gate_gen_tb.sv
`timescale 1ns/1ps
module csi_gate_gen_tb;
  localparam int DW = 12;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic signed [DW-1:0] carrier, mod_a, mod_b, mod_c;
  logic        [8:0]    phase;
  logic        [5:0]    gate;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  csi_gate_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_i (carrier),
    .mod_a_i   (mod_a),
    .mod_b_i   (mod_b),
    .mod_c_i   (mod_c),
    .phase_i   (phase),
    .gate_o    (gate)
  );

  // Behavioural reference from the requirements.
  function automatic logic [5:0] model(int c, int a, int b, int d, int ph);
    int   m[3];
    bit   lb[3];
    int   up_sw[3];
    int   lo_sw[3];
    logic [5:0] g;
    int   leg;
    m = '{a, b, d};
    up_sw = '{1, 3, 5};
    lo_sw = '{4, 6, 2};
    g = '0;
    foreach (m[i]) lb[i] = (m[i] > c);
    if (lb[0] == lb[1] && lb[1] == lb[2]) begin
      if (ph < 120) leg = 0;
      else if (ph < 240) leg = 1;
      else leg = 2;
      g[up_sw[leg]-1] = 1'b1;
      g[lo_sw[leg]-1] = 1'b1;
    end else begin
      for (int i = 0; i < 3; i++) begin
        int n;
        n = (i + 1) % 3;
        if (lb[i] && !lb[n]) g[up_sw[i]-1] = 1'b1;
        if (!lb[i] && lb[n]) g[lo_sw[i]-1] = 1'b1;
      end
    end
    return g;
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    checks++;
    if (gate !== exp) begin
      errors++;
      $display("FAIL %s: gate_o actual %b expected %b", tag, gate, exp);
    end
  endtask

  task automatic drive(int c, int a, int b, int d, int ph);
    carrier = DW'(c);
    mod_a   = DW'(a);
    mod_b   = DW'(b);
    mod_c   = DW'(d);
    phase   = 9'(ph);
  endtask

  // Drive at the falling edge, check just after the following rising edge.
  task automatic apply(string tag, int c, int a, int b, int d, int ph);
    @(negedge clk);
    drive(c, a, b, d, ph);
    @(posedge clk);
    #1;
    check(tag, model(c, a, b, d, ph));
  endtask

  task automatic check_pairs(string tag);
    int up, lo;
    up = int'(gate[0]) + int'(gate[2]) + int'(gate[4]);
    lo = int'(gate[3]) + int'(gate[5]) + int'(gate[1]);
    checks++;
    if (up != 1 || lo != 1) begin
      errors++;
      $display("FAIL %s: upper count %0d lower count %0d expected 1 and 1", tag, up, lo);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int car, dir;
    rst_n = 1'b0;
    drive(0, 100, -100, 50, 10);
    repeat (3) @(posedge clk);
    #1;
    check("R8 in reset", 6'b000000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 after release before edge", 6'b000000);
    @(posedge clk);
    #1;
    check("R7 first edge", model(0, 100, -100, 50, 10));

    // R1 ties and sign handling
    apply("R1 tie on leg a", 0, 0, 5, -5, 10);
    apply("R1 tie on all legs", -7, -7, -7, -7, 130);
    apply("R1 negative carrier", -2048, -2047, -2048, 2047, 250);
    apply("R1 max carrier", 2047, 2047, -1, 2047, 300);

    // R3 each mixed leg pattern (a,b,c bits)
    apply("R3 pattern 100", 0, 10, -10, -10, 0);
    apply("R3 pattern 110", 0, 10, 10, -10, 0);
    apply("R3 pattern 010", 0, -10, 10, -10, 0);
    apply("R3 pattern 011", 0, -10, 10, 10, 0);
    apply("R3 pattern 001", 0, -10, -10, 10, 0);
    apply("R3 pattern 101", 0, 10, -10, 10, 0);

    // R4 and R5 shorting with every window edge
    apply("R5 phase 0 leg a", 0, -1, -1, -1, 0);
    apply("R5 phase 119 leg a", 0, 5, 5, 5, 119);
    apply("R5 phase 120 leg b", 0, 5, 5, 5, 120);
    apply("R5 phase 239 leg b", 0, -5, -5, -5, 239);
    apply("R5 phase 240 leg c", 0, -5, -5, -5, 240);
    apply("R5 phase 359 leg c", 0, 5, 5, 5, 359);
    apply("R5 phase 360 leg c", 0, 5, 5, 5, 360);
    apply("R5 phase 511 leg c", 0, -5, -5, -5, 511);
    apply("R4 phase ignored when mixed", 0, 5, -5, 5, 200);

    // R7 mid-cycle input change holds until the next edge
    apply("R7 before change", 0, 10, -10, -10, 0);
    drive(0, -10, -10, -10, 200);
    #1;
    check("R7 hold between edges", model(0, 10, -10, -10, 0));
    @(posedge clk);
    #1;
    check("R7 update on edge", model(0, -10, -10, -10, 200));

    // Sweep: triangle carrier, random samples with forced ties, R2 R3 R4 R6
    car = -2000;
    dir = 37;
    for (int n = 0; n < 4000; n++) begin
      int a, b, d, ph;
      a  = int'($urandom_range(0, 4095)) - 2048;
      b  = int'($urandom_range(0, 4095)) - 2048;
      d  = int'($urandom_range(0, 4095)) - 2048;
      if ($urandom_range(0, 9) == 0) a = car;
      if ($urandom_range(0, 9) == 0) b = car;
      if ($urandom_range(0, 15) == 0) begin a = car + 3; b = car + 9; d = car + 1; end
      ph = (n * 7) % 512;
      apply("R2 R3 R4 sweep", car, a, b, d, ph);
      check_pairs("R6 sweep");
      car += dir;
      if (car > 2000 || car < -2000) begin
        dir = -dir;
        car += 2 * dir;
      end
    end

    // Reset asserted mid-run clears the gates
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 asynchronous clear", 6'b000000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule